// File: doc/BRIEF.md
# General-Purpose Pin Register Bank

A register block that controls 32 general-purpose pins from a simple memory-mapped bus. Each pin has a direction bit and an output latch. The block drives an output-enable and an output level to each pad. The pad levels pass through a multi-flop synchronizer into the block's clock domain, and software can read them back from there.

Software never has to read, modify and write the output latch. A write to the set port raises the latch bits that are written as 1, and a write to the clear port lowers them. All other bits keep their value. The output latch can be loaded while a pin is still an input, so when the pin becomes an output it drives the intended level from its first cycle. The input-data register always shows the synchronized pad level, even for pins that are driving. Because of the synchronizer, a read taken right after an output change can still return the old level.

The bus write is taken on the clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i` and reflects register state after the last edge. Word addresses: 0 direction, 1 set, 2 clear, 3 input data.

Top module: `gpio_regfile`

## Requirements
- R1: After reset, every direction bit is 1 (all pins are inputs), so `pad_oe_o` is all zeros, and every output latch bit is 0, so `pad_out_o` is all zeros.
- R2: A write to address 0 stores `wdata_i` in the direction register, and address 0 reads it back. `pad_oe_o` bit n is 1 exactly when direction bit n is 0 (1 means input, 0 means output).
- R3: A write to address 1 sets to 1 each output latch bit whose `wdata_i` bit is 1. Latch bits written as 0 are unchanged.
- R4: A write to address 2 clears to 0 each output latch bit whose `wdata_i` bit is 1. Latch bits written as 0 are unchanged. If a set and a clear reach the same latch bit together, the clear wins.
- R5: Reads of address 1 and of address 2 both return the current output latch, which is also driven on `pad_out_o`.
- R6: A read of address 3 returns the synchronized pad level of all pins, including pins configured as outputs. Writes to address 3 have no effect.
- R7: A change on `pad_i` shows in an address 3 read after exactly SYNC_STAGES rising clock edges (2 by default), and not after one edge.
- R8: The output latch can be written while a pin is an input. When that pin's direction bit is then written to 0, `pad_oe_o` and the preloaded level on `pad_out_o` appear in the same cycle.
- R9: Addresses 4 and above read as zero, and writes to them change no register.
- R10: A bus cycle with `req_i` low, or a read (`we_i` low), changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also the clock the pads are synchronized to |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | NUM_PINS | Write data, one bit per pin |
| rdata_o | output | NUM_PINS | Read data for `addr_i` |
| pad_i | input | NUM_PINS | Pad levels, asynchronous to the clock |
| pad_oe_o | output | NUM_PINS | Output enable per pad, high means drive |
| pad_out_o | output | NUM_PINS | Output level per pad |

## Verification
The bench builds the block with its defaults: NUM_PINS = 32, SYNC_STAGES = 2 and ADDR_W = 4. With these values the top and bottom pin bits can both be checked, the exact two-edge read-back latency can be pinned down cycle by cycle, and the unmapped addresses 4 to 15 can be reached to show that they read zero and ignore writes. The pad pattern differs from the output latch on pins configured as outputs, so a read-back that returned the latch instead of the pad would be seen.

// File: rtl/gpio_regfile_pkg.sv
package gpio_regfile_pkg;
  localparam int unsigned REG_DIR = 0;
  localparam int unsigned REG_SET = 1;
  localparam int unsigned REG_CLR = 2;
  localparam int unsigned REG_IN  = 3;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_regfile_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  output logic                dir_we_o,
  output logic [NUM_PINS-1:0] set_mask_o,
  output logic [NUM_PINS-1:0] clr_mask_o,
  output logic [NUM_PINS-1:0] rdata_o
);
  logic wr;
  logic hit_dir, hit_set, hit_clr, hit_in;

  assign wr      = req_i & we_i;
  assign hit_dir = (addr_i == ADDR_W'(REG_DIR));
  assign hit_set = (addr_i == ADDR_W'(REG_SET));
  assign hit_clr = (addr_i == ADDR_W'(REG_CLR));
  assign hit_in  = (addr_i == ADDR_W'(REG_IN));

  assign dir_we_o   = wr & hit_dir;
  assign set_mask_o = (wr & hit_set) ? wdata_i : '0;
  assign clr_mask_o = (wr & hit_clr) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (hit_dir)                rdata_o = dir_i;
    else if (hit_set | hit_clr) rdata_o = latch_i;
    else if (hit_in)            rdata_o = pin_lvl_i;
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dir_we_i,
  input  logic [NUM_PINS-1:0] dir_wdata_i,
  input  logic [NUM_PINS-1:0] set_mask_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] dir_q_o,
  output logic [NUM_PINS-1:0] latch_q_o
);
  logic [NUM_PINS-1:0] dir_q, latch_q, latch_d;

  // clear has priority over set on the same bit
  assign latch_d = (latch_q | set_mask_i) & ~clr_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '1;
      latch_q <= '0;
    end else begin
      if (dir_we_i) dir_q <= dir_wdata_i;
      latch_q <= latch_d;
    end
  end

  assign dir_q_o   = dir_q;
  assign latch_q_o = latch_q;

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> dir_q == $past(dir_wdata_i));

  p_dir_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_we_i |=> $stable(dir_q));

  p_set_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (latch_q & ($past(set_mask_i) & ~$past(clr_mask_i)))
             == ($past(set_mask_i) & ~$past(clr_mask_i)));

  p_clr_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (latch_q & $past(clr_mask_i)) == '0);

  p_latch_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mask_i == '0 && clr_mask_i == '0) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] lvl_o
);
  logic [NUM_PINS-1:0] stg_q [SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= pad_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[SYNC_STAGES-1];

  // edges since reset, saturating; gates the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_lat_chk
    p_sync_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2) |-> lvl_o == $past(pad_i, 2));
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o
);
  logic                dir_we;
  logic [NUM_PINS-1:0] set_mask, clr_mask, dir_q, latch_q, pin_lvl;

  gpio_bus_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .dir_i      (dir_q),
    .latch_i    (latch_q),
    .pin_lvl_i  (pin_lvl),
    .dir_we_o   (dir_we),
    .set_mask_o (set_mask),
    .clr_mask_o (clr_mask),
    .rdata_o    (rdata_o)
  );

  gpio_pin_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_we_i    (dir_we),
    .dir_wdata_i (wdata_i),
    .set_mask_i  (set_mask),
    .clr_mask_i  (clr_mask),
    .dir_q_o     (dir_q),
    .latch_q_o   (latch_q)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_i),
    .lvl_o  (pin_lvl)
  );

  // direction 1 = input, so drive only where the bit is 0
  assign pad_oe_o  = ~dir_q;
  assign pad_out_o = latch_q;

  p_oe_follows_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == '0) |=> pad_oe_o == ~$past(wdata_i));

  p_preload_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && (addr_i == ADDR_W'(1) || addr_i == ADDR_W'(2)))
      |=> $stable(pad_out_o));
endmodule

// File: tb/gpio_regfile_bench.sv
module gpio_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int AW = 4;

  typedef struct packed {
    logic [7:0]    req_no;
    logic          req;
    logic          we;
    logic [AW-1:0] addr;
    logic [N-1:0]  wdata;
    logic [AW-1:0] chk_addr;
    logic [N-1:0]  exp_rd;
    logic [N-1:0]  exp_oe;
    logic [N-1:0]  exp_out;
  } vec_t;

  localparam logic [N-1:0] PAD_A = 32'hA5A5_0F0F;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R2: direction write, low half outputs
    '{8'd2,  1'b1, 1'b1, 4'd0, 32'hFFFF_0000, 4'd0, 32'hFFFF_0000, 32'h0000_FFFF, 32'h0},
    // R3: set low byte, read via set address (R5)
    '{8'd3,  1'b1, 1'b1, 4'd1, 32'h0000_00FF, 4'd1, 32'h0000_00FF, 32'h0000_FFFF, 32'h0000_00FF},
    // R5: set top and bottom bits, read via clear address
    '{8'd5,  1'b1, 1'b1, 4'd1, 32'h8000_0001, 4'd2, 32'h8000_00FF, 32'h0000_FFFF, 32'h8000_00FF},
    // R4: clear low nibble
    '{8'd4,  1'b1, 1'b1, 4'd2, 32'h0000_000F, 4'd1, 32'h8000_00F0, 32'h0000_FFFF, 32'h8000_00F0},
    // R4: clear with zero mask changes nothing
    '{8'd4,  1'b1, 1'b1, 4'd2, 32'h0000_0000, 4'd2, 32'h8000_00F0, 32'h0000_FFFF, 32'h8000_00F0},
    // R6: write to input register ignored; pad level read incl. output pins
    '{8'd6,  1'b1, 1'b1, 4'd3, 32'hFFFF_FFFF, 4'd3, PAD_A,         32'h0000_FFFF, 32'h8000_00F0},
    // R9: unmapped write ignored, reads zero
    '{8'd9,  1'b1, 1'b1, 4'd7, 32'h0000_0000, 4'd7, 32'h0,         32'h0000_FFFF, 32'h8000_00F0},
    // R10: req low write ignored
    '{8'd10, 1'b0, 1'b1, 4'd0, 32'h0000_0000, 4'd0, 32'hFFFF_0000, 32'h0000_FFFF, 32'h8000_00F0},
    // R10: read cycle to set address writes nothing
    '{8'd10, 1'b1, 1'b0, 4'd1, 32'hFFFF_FFFF, 4'd1, 32'h8000_00F0, 32'h0000_FFFF, 32'h8000_00F0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0, pad = '0;
  logic [N-1:0]  rdata, oe, dout;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regfile u_gpio_regfile (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .pad_i (pad), .pad_oe_o (oe), .pad_out_o (dout)
  );

  task automatic check(input string what, input int r, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a);
    addr = a; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    peek(4'd0); check("reset dir", 1, rdata, '1);
    peek(4'd1); check("reset latch", 1, rdata, '0);
    check("reset oe", 1, oe, '0);
    check("reset out", 1, dout, '0);

    pad = PAD_A;
    repeat (3) @(posedge clk);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req = VECS[i].req; we = VECS[i].we; addr = VECS[i].addr; wdata = VECS[i].wdata;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      peek(VECS[i].chk_addr);
      check($sformatf("vec %0d rdata", i), int'(VECS[i].req_no), rdata, VECS[i].exp_rd);
      check($sformatf("vec %0d oe", i),    int'(VECS[i].req_no), oe,    VECS[i].exp_oe);
      check($sformatf("vec %0d out", i),   int'(VECS[i].req_no), dout,  VECS[i].exp_out);
    end

    // R7: exact synchronizer latency
    @(negedge clk); pad = 32'h5A5A_F0F0; addr = 4'd3;
    @(posedge clk); @(negedge clk); #1;
    check("pad after one edge", 7, rdata, PAD_A);
    @(posedge clk); @(negedge clk); #1;
    check("pad after two edges", 7, rdata, 32'h5A5A_F0F0);

    // R8: preload while input, then switch to output
    bus_write(4'd0, '1);
    bus_write(4'd2, '1);
    bus_write(4'd1, 32'h0001_0000);
    #1;
    check("preload oe off", 8, oe, '0);
    check("preload level", 8, dout, 32'h0001_0000);
    bus_write(4'd0, 32'hFFFE_FFFF);
    #1;
    check("switch oe", 8, oe, 32'h0001_0000);
    check("switch level", 8, dout, 32'h0001_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule